// File: doc/BRIEF.md
# Serial Control Register File

This block is the configuration front end of a dual-channel converter datapath. A host reaches it over a four-wire serial port: chip select, serial clock, data in and data out. Each access is one frame that names a register and then carries one data byte. A write frame stores the byte in that register. A read frame returns the register's contents on the data-out pin.

The register bank drives its contents out as decoded control fields. These cover per-channel and full power-down, holding the interpolator clock, interpolation rate, filter response, modulation frequency and mode, the data-port format, fine and coarse gain codes, and a 10-bit offset code.

Two register bits act on the port itself. The first selects whether bytes travel most-significant or least-significant bit first, and the change applies only from the following frame. The second is a soft-reset bit that returns the whole bank to its defaults and then reads back as zero.

The serial pins are sampled by the block's own clock. The serial clock must therefore run well below that clock.

Top module: `ctl_serial_regfile`

## Requirements
- R1: A frame is 16 rising SCLK edges with CS_N low. The first byte has bit 7 as the access flag (1 = read, 0 = write) and bits 6:0 as the address, and the second byte is the data. Inputs are taken on SCLK rising edges. In a read frame, SDO presents the register's data bits, changing on SCLK falling edges, and SDO_OE is high from the eighth rising edge until CS_N returns high.
- R2: Register 0x00 bit 6 selects the bit order for both bytes: 0 (default) sends bit 7 first, 1 sends bit 0 first. A new value takes effect from the first frame that starts after CS_N has gone high.
- R3: Writing a byte with bit 5 set to register 0x00 restores every register, register 0x00 included, to its default. All other bits of that same byte are discarded, and bit 5 always reads 0.
- R4: Register 0x00 bit 3 drives pd_i, bit 2 drives pd_q and bit 4 drives interp_hold. pd_all is high exactly when pd_i and pd_q are both high. The serial port keeps reading and writing in that state.
- R5: Register 0x01 resets to 0xD4 and maps as follows: bits 7:6 interp_rate (00 = 1x, 01 = 2x, 10 = 4x, 11 = 8x), bit 5 fir_highpass, bits 4:3 mod_sel, bit 2 mod_real, bit 1 mod_sign_pos. Bit 0 reads 0.
- R6: Register 0x02 resets to 0x00 and maps as follows: bit 7 fmt_offset_bin, bit 6 port_dual, bit 5 dclk_alt_pin, bit 4 dclk_falling, bit 3 dclk_out, bit 2 sync_disable. Bits 1:0 read 0.
- R7: Register 0x04 is fine_gain (8 bits, reset 0x00). Register 0x05 bits 3:0 are coarse_gain (reset 0xF), and its bits 7:4 read 0.
- R8: offset_code is register 0x07 bits 1:0 above register 0x06 bits 7:0, and it resets to zero. Register 0x07 bits 7:2 read 0.
- R9: Address 0x03 and addresses 0x08 to 0x7F read 0. Writes to them change no register and no output.
- R10: A frame in which CS_N rises before the sixteenth rising edge writes nothing. SDO_OE is low while CS_N is high and after reset.
- R11: Register 0x00 bits 7, 1 and 0 read 0, and register 0x00 resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo during read data |
| pd_i | output | 1 | I channel power-down |
| pd_q | output | 1 | Q channel power-down |
| pd_all | output | 1 | Full power-down, both channels off |
| interp_hold | output | 1 | Stop interpolator clock, hold outputs |
| interp_rate | output | 2 | Interpolation factor code |
| fir_highpass | output | 1 | Final filter highpass response |
| mod_sel | output | 2 | Modulation frequency code |
| mod_real | output | 1 | Real (1) or complex (0) modulation |
| mod_sign_pos | output | 1 | Complex modulation sign positive |
| fmt_offset_bin | output | 1 | Data words in offset binary |
| port_dual | output | 1 | Separate I and Q data buses |
| dclk_alt_pin | output | 1 | Data clock on alternate pin |
| dclk_falling | output | 1 | Latch data on falling data-clock edge |
| dclk_out | output | 1 | Data clock pin is an output |
| sync_disable | output | 1 | Data synchronizer disabled |
| fine_gain | output | 8 | Fine gain code |
| coarse_gain | output | 4 | Coarse gain code |
| offset_code | output | 10 | Offset magnitude code |

## Verification
The two functions that meet in one cycle are the soft reset and an ordinary register write. Both are carried by the same byte to register 0x00: a single write sets the soft-reset bit together with the bit-order bit and both power-down bits, and it is sent in least-significant-first order. The result is judged afterwards at the ports. Every decoded output must be back at its default, and a following frame in most-significant-first order must read register 0x00 as zero. That shows the reset won over the stored bits, and that the order bit itself was cleared before the next frame began.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   localparam int CTL_DATA_W   = 8;
   localparam int CTL_ADDR_W   = 7;
   localparam int CTL_NUM_REGS = 8;

   // control bits of register 0 that act on the port itself
   localparam int SRST_BIT  = 5;
   localparam int ORDER_BIT = 6;

   typedef struct packed {
      logic       lsb_first;
      logic       interp_hold;
      logic       pd_i;
      logic       pd_q;
      logic [1:0] interp_rate;
      logic       fir_highpass;
      logic [1:0] mod_sel;
      logic       mod_real;
      logic       mod_sign_pos;
      logic       fmt_offset_bin;
      logic       port_dual;
      logic       dclk_alt_pin;
      logic       dclk_falling;
      logic       dclk_out;
      logic       sync_disable;
      logic [7:0] fine_gain;
      logic [3:0] coarse_gain;
      logic [9:0] offset_code;
   } ctl_fields_t;

   function automatic logic [CTL_DATA_W-1:0] reg_default(input int idx);
      case (idx)
         1:       return 8'hD4;
         5:       return 8'h0F;
         default: return 8'h00;
      endcase
   endfunction

   // bits that hold state; zero mask means no storage at that address
   function automatic logic [CTL_DATA_W-1:0] reg_mask(input int idx);
      case (idx)
         0:       return 8'h5C;
         1:       return 8'hFE;
         2:       return 8'hFC;
         4:       return 8'hFF;
         5:       return 8'h0F;
         6:       return 8'hFF;
         7:       return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ctl_bit_sync.sv
module ctl_bit_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ctl_bit_sync: STAGES must be at least 1");
      end

      if (STAGES <= 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= RST_VAL;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= {STAGES{RST_VAL}};
            else        ff <= {ff[STAGES-2:0], d};
         end
         assign q = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ctl_spi_frame.sv
module ctl_spi_frame #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              cfg_lsb_first,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int FRAME_BITS = 2 * DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int IDX_W      = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_HLST = CNT_W'(DATA_W - 1);

   generate
      if (ADDR_W != DATA_W - 1) begin : g_bad_hdr
         $error("ctl_spi_frame: header byte must hold flag plus address");
      end
   endgenerate

   logic sclk_s, cs_s, sdi_s;

   ctl_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   ctl_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   ctl_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   logic              sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] nxt_byte;
   logic              order_lsb;
   logic              rd_flag;
   logic              sdo_q;
   logic [IDX_W-1:0]  out_idx;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_comb begin
      if (order_lsb) nxt_byte = {sdi_s, sh_q[DATA_W-1:1]};
      else           nxt_byte = {sh_q[DATA_W-2:0], sdi_s};
   end

   // data phase slot k = cnt - DATA_W; first slot is bit 0 or bit DATA_W-1
   always_comb begin
      if (order_lsb) out_idx = IDX_W'(cnt_q - CNT_HDR);
      else           out_idx = IDX_W'(CNT_LAST - cnt_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         cnt_q     <= '0;
         sh_q      <= '0;
         order_lsb <= 1'b0;
         rd_flag   <= 1'b0;
         sdo_q     <= 1'b0;
         acc_addr  <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
      end else begin
         sclk_d <= sclk_s;
         wr_en  <= 1'b0;
         if (cs_s) begin
            // idle: order for the next frame follows the register
            cnt_q     <= '0;
            rd_flag   <= 1'b0;
            sdo_q     <= 1'b0;
            order_lsb <= cfg_lsb_first;
         end else begin
            if (rise && (cnt_q < CNT_END)) begin
               sh_q  <= nxt_byte;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_HLST) begin
                  rd_flag  <= nxt_byte[DATA_W-1];
                  acc_addr <= nxt_byte[ADDR_W-1:0];
               end
               if ((cnt_q == CNT_LAST) && !rd_flag) begin
                  wr_en   <= 1'b1;
                  wr_data <= nxt_byte;
               end
            end
            if (fall && rd_flag && (cnt_q >= CNT_HDR) && (cnt_q < CNT_END)) begin
               sdo_q <= rd_data[out_idx];
            end
         end
      end
   end

   assign sdo    = sdo_q;
   assign sdo_oe = ~cs_s & rd_flag & (cnt_q >= CNT_HDR);

   // R1
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R1
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt_q == CNT_END));

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !wr_en);

   // R2
   order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && $past(!cs_s)) |-> $stable(order_lsb));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
   import ctlreg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 7,
   parameter int NUM_REGS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output ctl_fields_t       fields
);

   localparam int RA_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (DATA_W != CTL_DATA_W) begin : g_bad_width
         $error("ctl_regbank: field map needs 8-bit registers");
      end
      if ((NUM_REGS < CTL_NUM_REGS) || (NUM_REGS >= (1 << ADDR_W))) begin : g_bad_depth
         $error("ctl_regbank: NUM_REGS out of range");
      end
   endgenerate

   function automatic logic [NUM_REGS*DATA_W-1:0] defaults_flat();
      logic [NUM_REGS*DATA_W-1:0] v;
      v = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (reg_mask(i) != '0) v[i*DATA_W +: DATA_W] = reg_default(i);
      end
      return v;
   endfunction

   localparam logic [NUM_REGS*DATA_W-1:0] DEF_FLAT = defaults_flat();

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic                            soft_rst;

   // R3: reset bit in a register-0 write wins over the stored bits
   assign soft_rst = wr_en && (acc_addr == '0) && wr_data[SRST_BIT];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         if (reg_mask(g) == '0) begin : g_hole
            // R9: unused address, nothing stored
            assign regs_q[g] = '0;
         end else begin : g_store
            localparam logic [DATA_W-1:0] DEF  = reg_default(g);
            localparam logic [DATA_W-1:0] MASK = reg_mask(g);
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                     q <= DEF;
               else if (soft_rst)                              q <= DEF;
               else if (wr_en && (acc_addr == ADDR_W'(g)))     q <= wr_data & MASK;
            end
            assign regs_q[g] = q;
         end
      end
   endgenerate

   always_comb begin
      if (int'(acc_addr) < NUM_REGS) rd_data = regs_q[acc_addr[RA_W-1:0]];
      else                           rd_data = '0;
   end

   always_comb begin
      fields.lsb_first      = regs_q[0][ORDER_BIT];
      fields.interp_hold    = regs_q[0][4];
      fields.pd_i           = regs_q[0][3];
      fields.pd_q           = regs_q[0][2];
      fields.interp_rate    = regs_q[1][7:6];
      fields.fir_highpass   = regs_q[1][5];
      fields.mod_sel        = regs_q[1][4:3];
      fields.mod_real       = regs_q[1][2];
      fields.mod_sign_pos   = regs_q[1][1];
      fields.fmt_offset_bin = regs_q[2][7];
      fields.port_dual      = regs_q[2][6];
      fields.dclk_alt_pin   = regs_q[2][5];
      fields.dclk_falling   = regs_q[2][4];
      fields.dclk_out       = regs_q[2][3];
      fields.sync_disable   = regs_q[2][2];
      fields.fine_gain      = regs_q[4];
      fields.coarse_gain    = regs_q[5][3:0];
      fields.offset_code    = {regs_q[7][1:0], regs_q[6]};
   end

   // R3
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (regs_q == DEF_FLAT));

   // R9
   unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(acc_addr) >= NUM_REGS)) |=> $stable(regs_q));

endmodule

// File: rtl/ctl_serial_regfile.sv
module ctl_serial_regfile
   import ctlreg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_REGS    = CTL_NUM_REGS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       sdi,
   output logic       sdo,
   output logic       sdo_oe,
   output logic       pd_i,
   output logic       pd_q,
   output logic       pd_all,
   output logic       interp_hold,
   output logic [1:0] interp_rate,
   output logic       fir_highpass,
   output logic [1:0] mod_sel,
   output logic       mod_real,
   output logic       mod_sign_pos,
   output logic       fmt_offset_bin,
   output logic       port_dual,
   output logic       dclk_alt_pin,
   output logic       dclk_falling,
   output logic       dclk_out,
   output logic       sync_disable,
   output logic [7:0] fine_gain,
   output logic [3:0] coarse_gain,
   output logic [9:0] offset_code
);

   localparam int DW = CTL_DATA_W;
   localparam int AW = CTL_ADDR_W;

   logic [AW-1:0] acc_addr;
   logic          wr_en;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   ctl_fields_t   fields;

   ctl_spi_frame #(
      .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC_STAGES)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .cfg_lsb_first(fields.lsb_first),
      .rd_data(rd_data),
      .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
      .sdo(sdo), .sdo_oe(sdo_oe)
   );

   ctl_regbank #(
      .DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NUM_REGS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .acc_addr(acc_addr), .wr_data(wr_data),
      .rd_data(rd_data), .fields(fields)
   );

   // R4: both channels down means full power-down
   assign pd_i           = fields.pd_i;
   assign pd_q           = fields.pd_q;
   assign pd_all         = fields.pd_i & fields.pd_q;
   assign interp_hold    = fields.interp_hold;
   assign interp_rate    = fields.interp_rate;
   assign fir_highpass   = fields.fir_highpass;
   assign mod_sel        = fields.mod_sel;
   assign mod_real       = fields.mod_real;
   assign mod_sign_pos   = fields.mod_sign_pos;
   assign fmt_offset_bin = fields.fmt_offset_bin;
   assign port_dual      = fields.port_dual;
   assign dclk_alt_pin   = fields.dclk_alt_pin;
   assign dclk_falling   = fields.dclk_falling;
   assign dclk_out       = fields.dclk_out;
   assign sync_disable   = fields.sync_disable;
   assign fine_gain      = fields.fine_gain;
   assign coarse_gain    = fields.coarse_gain;
   assign offset_code    = fields.offset_code;

endmodule

// File: tb/ctl_serial_regfile_tb.sv
module ctl_serial_regfile_tb;

   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic sdi = 1'b0;

   logic       sdo, sdo_oe, pd_i, pd_q, pd_all, interp_hold;
   logic [1:0] interp_rate, mod_sel;
   logic       fir_highpass, mod_real, mod_sign_pos;
   logic       fmt_offset_bin, port_dual, dclk_alt_pin, dclk_falling, dclk_out, sync_disable;
   logic [7:0] fine_gain;
   logic [3:0] coarse_gain;
   logic [9:0] offset_code;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 0;
   bit  cur_lsb = 0;
   logic oe_all;

   always #2 clk = ~clk;

   ctl_serial_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .pd_i(pd_i), .pd_q(pd_q), .pd_all(pd_all),
      .interp_hold(interp_hold), .interp_rate(interp_rate), .fir_highpass(fir_highpass),
      .mod_sel(mod_sel), .mod_real(mod_real), .mod_sign_pos(mod_sign_pos),
      .fmt_offset_bin(fmt_offset_bin), .port_dual(port_dual), .dclk_alt_pin(dclk_alt_pin),
      .dclk_falling(dclk_falling), .dclk_out(dclk_out), .sync_disable(sync_disable),
      .fine_gain(fine_gain), .coarse_gain(coarse_gain), .offset_code(offset_code)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_mask(input int a);
      case (a)
         0: return 8'h5C; 1: return 8'hFE; 2: return 8'hFC; 4: return 8'hFF;
         5: return 8'h0F; 6: return 8'hFF; 7: return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] m_def(input int a);
      case (a)
         1: return 8'hD4; 5: return 8'h0F;
         default: return 8'h00;
      endcase
   endfunction

   task automatic xfer(input bit lsb, input bit rd, input logic [6:0] a,
                       input logic [7:0] wd, input int nbits, output logic [7:0] rdv);
      logic [7:0] hdr;
      hdr = {rd, a};
      rdv = '0;
      oe_all = 1'b1;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         logic [7:0] by;
         int p;
         by = (i < 8) ? hdr : wd;
         p = lsb ? (i % 8) : 7 - (i % 8);
         sdi = by[p];
         repeat (HALF) @(negedge clk);
         if (i >= 8) begin
            rdv[lsb ? (i - 8) : 15 - i] = sdo;
            if (rd) oe_all = oe_all & sdo_oe;
         end
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      xfer(cur_lsb, 1'b0, a, d, 16, dummy);
   endtask

   task automatic rd(input logic [6:0] a, output logic [7:0] v);
      xfer(cur_lsb, 1'b1, a, 8'h00, 16, v);
   endtask

   task automatic chk_defaults(input string tag);
      chk({tag, " R11 R4 pd"}, {pd_i, pd_q, pd_all, interp_hold}, 0);
      chk({tag, " R5 reg1 fields"},
          {interp_rate, fir_highpass, mod_sel, mod_real, mod_sign_pos}, 7'b11_0_10_1_0);
      chk({tag, " R6 reg2 fields"},
          {fmt_offset_bin, port_dual, dclk_alt_pin, dclk_falling, dclk_out, sync_disable}, 0);
      chk({tag, " R7 fine"}, fine_gain, 0);
      chk({tag, " R7 coarse"}, coarse_gain, 4'hF);
      chk({tag, " R8 offset"}, offset_code, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] pats [4];
      logic [7:0] p0 [6];
      pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
      p0[0] = 8'h1C; p0[1] = 8'h08; p0[2] = 8'h04; p0[3] = 8'h10; p0[4] = 8'h83; p0[5] = 8'h00;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state
      chk("R10 sdo_oe after reset", sdo_oe, 0);
      chk_defaults("reset");
      for (int a = 0; a < 16; a++) begin
         rd(7'(a), v);
         chk($sformatf("R5 R7 R9 R11 default read addr %0d", a), v, m_def(a));
      end
      rd(7'h7F, v);
      chk("R9 read 0x7F", v, 0);
      chk("R1 sdo_oe held during read data", oe_all, 1);

      // R9 unused writes and field sweep on registers 1..15 and 0x7F
      for (int a = 1; a < 17; a++) begin
         int aa;
         aa = (a == 16) ? 127 : a;
         for (int k = 0; k < 4; k++) begin
            wr(7'(aa), pats[k]);
            rd(7'(aa), v);
            chk($sformatf("R1 R9 readback addr %0d pat %0h", aa, pats[k]), v, pats[k] & m_mask(aa));
            case (aa)
               1: chk("R5 reg1 fields",
                      {interp_rate, fir_highpass, mod_sel, mod_real, mod_sign_pos}, pats[k][7:1]);
               2: chk("R6 reg2 fields",
                      {fmt_offset_bin, port_dual, dclk_alt_pin, dclk_falling, dclk_out, sync_disable},
                      pats[k][7:2]);
               4: chk("R7 fine_gain", fine_gain, pats[k]);
               5: chk("R7 coarse_gain", coarse_gain, pats[k][3:0]);
               6: chk("R8 offset low", offset_code[7:0], pats[k]);
               7: chk("R8 offset high", offset_code[9:8], pats[k][1:0]);
               default: chk("R9 unused write leaves reg0 outputs",
                            {pd_i, pd_q, interp_hold}, 0);
            endcase
         end
      end

      // register 0 power controls
      for (int k = 0; k < 6; k++) begin
         wr(7'h00, p0[k]);
         rd(7'h00, v);
         chk("R11 reg0 readback", v, p0[k] & 8'h5C);
         chk("R4 power outputs", {pd_i, pd_q, interp_hold, pd_all},
             {p0[k][3], p0[k][2], p0[k][4], p0[k][3] & p0[k][2]});
      end

      // R4 full power-down keeps the port alive
      wr(7'h00, 8'h0C);
      chk("R4 pd_all", pd_all, 1);
      wr(7'h06, 8'h33);
      rd(7'h06, v);
      chk("R4 port alive in full power-down", v, 8'h33);

      // R2 bit order switch applies from the next frame
      wr(7'h00, 8'h40);
      cur_lsb = 1;
      rd(7'h00, v);
      chk("R2 lsb-first read of reg0", v, 8'h40);
      wr(7'h04, 8'h1E);
      chk("R2 lsb-first write fine_gain", fine_gain, 8'h1E);
      rd(7'h04, v);
      chk("R2 lsb-first read reg4", v, 8'h1E);
      wr(7'h02, 8'h84);
      chk("R2 R6 lsb-first reg2", {fmt_offset_bin, sync_disable, port_dual}, 3'b110);

      // R3 soft reset in the same byte as other register-0 bits
      wr(7'h00, 8'h6C);
      cur_lsb = 0;
      chk_defaults("R3 after soft reset");
      rd(7'h00, v);
      chk("R3 reg0 back to default in msb order", v, 8'h00);
      rd(7'h04, v);
      chk("R3 reg4 default", v, 8'h00);
      rd(7'h01, v);
      chk("R3 R5 reg1 default", v, 8'hD4);

      // R3 soft reset from msb order with state present
      wr(7'h05, 8'h03);
      wr(7'h07, 8'h02);
      wr(7'h00, 8'h20);
      chk_defaults("R3 second soft reset");

      // R10 aborted frame
      wr(7'h04, 8'h55);
      xfer(cur_lsb, 1'b0, 7'h04, 8'hC3, 12, v);
      rd(7'h04, v);
      chk("R10 aborted write ignored", v, 8'h55);
      chk("R10 sdo_oe low with cs_n high", sdo_oe, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule